// File: doc/BRIEF.md
# Paged 32-bit Register Bridge over Clause-22 MDIO

This block lets a host reach 32-bit switch registers over a management bus that only moves 16-bit words. The switch shows its register space through a paged window. The host hands over one request at a time: an operation, a word address, write data and a mask. The bridge then runs the whole bus sequence alone. It writes the page number to a fixed page-select location. It waits a settle time of at least 5 µs. It then moves the two half-words of the target register at a PHY address and register number taken from the word address.

Three operations are supported: read, write, and an atomic read-modify-write. The modify step clears the masked bits of the old value and ORs in the new data. Each 16-bit command goes to a frame engine over a valid/ready handshake. The engine answers every command, read or write, with a one-cycle response strobe, and for reads that strobe carries the data. Host requests are never interleaved, so one request's page write and half-word accesses go out as one unbroken run of commands.

Top module: `pmdio_bridge`

## Requirements
- R1: A synchronous reset, applied at any point, returns the bridge to idle. In the cycle after reset, `req_ready` is 1, `done` is 0 and `mdio_cmd_valid` is 0. A request that was partly done is dropped and no further command is issued for it.
- R2: The first command of every request is a write to PHY 0x18, register 0. Its data is the 9-bit page `req_addr[15:7]`, zero-extended to 16 bits.
- R3: The first data command becomes valid exactly SETTLE_CYC+1 cycles after the cycle in which the page write's response arrives. SETTLE_CYC is the number of clock cycles in SETTLE_NS, rounded up, so the wait always covers at least 5 µs.
- R4: Data commands use PHY address `0x10 | req_addr[6:4]`. The low half-word sits at register `{req_addr[3:0],0}` and the high half-word at that register plus one.
- R5: Op 0 and op 3 are reads. Each issues a low-half read and then a high-half read, and returns `{high,low}` on `rdata`.
- R6: Op 1 is a write. It sends `req_wdata[15:0]` to the low register and then `req_wdata[31:16]` to the high register, and returns the written value on `rdata`.
- R7: Op 2 is a read-modify-write. It reads low and then high, computes `(old & ~req_mask) | req_wdata`, writes that value low half first and then high half, and returns it on `rdata`.
- R8: Only one bus command is outstanding at a time. No command is offered until the previous one has been answered. While a command is valid and not yet accepted, its PHY, register, data and direction stay unchanged.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the request ends. `done` is a one-cycle pulse that presents `rdata`, and `req_ready` returns to 1 in the next cycle. No bus command is offered while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle, request can be accepted |
| req_op | input | 2 | 0/3 read, 1 write, 2 read-modify-write |
| req_addr | input | 16 | Word address (byte address bits 17:2) |
| req_wdata | input | 32 | Write data or OR value |
| req_mask | input | 32 | Bits cleared by read-modify-write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Result, valid while done is 1 |
| mdio_cmd_valid | output | 1 | Bus command offered |
| mdio_cmd_ready | input | 1 | Frame engine takes the command |
| mdio_cmd_write | output | 1 | 1 write, 0 read |
| mdio_cmd_phy | output | 5 | PHY address of the command |
| mdio_cmd_reg | output | 5 | Register number of the command |
| mdio_cmd_data | output | 16 | Write data of the command |
| mdio_rsp_valid | input | 1 | Frame engine completed the outstanding command |
| mdio_rsp_data | input | 16 | Read data, valid with mdio_rsp_valid |

## Verification
The assertions assume the frame engine is well behaved. It raises `mdio_rsp_valid` only for a command it has already taken, at most once for that command, and it never answers during reset. Under that assumption, the single-outstanding rule and the settle-gap counter in the checker stay meaningful. The bench's engine model follows these rules. It polls on the falling edge, stalls `mdio_cmd_ready` for zero to two cycles, and answers after a latency of zero to two cycles. The reset-abort case is timed so that reset lands inside the settle wait, when no command is pending at the engine.

// File: rtl/pmdio_pkg.sv
package pmdio_pkg;

  localparam logic [4:0] PAGE_PHY      = 5'h18;
  localparam logic [4:0] PAGE_REG      = 5'h00;
  localparam logic [4:0] DATA_PHY_BASE = 5'h10;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_RMW   = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_PAGE, S_SETTLE, S_RLO, S_RHI, S_WLO, S_WHI, S_DONE
  } seq_state_e;

  // word address: [15:7] page, [6:4] phy select, [3:0] half-word pair index
  function automatic logic [8:0] page_of(input logic [15:0] wa);
    return wa[15:7];
  endfunction

  function automatic logic [4:0] phy_of(input logic [15:0] wa);
    return DATA_PHY_BASE | {2'b00, wa[6:4]};
  endfunction

  function automatic logic [4:0] lo_reg_of(input logic [15:0] wa);
    return {wa[3:0], 1'b0};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old_v,
                                        input logic [31:0] mask,
                                        input logic [31:0] new_v);
    return (old_v & ~mask) | new_v;
  endfunction

  function automatic logic is_cmd_state(input seq_state_e s);
    return (s == S_PAGE) || (s == S_RLO) || (s == S_RHI) ||
           (s == S_WLO) || (s == S_WHI);
  endfunction

endpackage

// File: rtl/pmdio_settle_timer.sv
module pmdio_settle_timer #(
  parameter int CYCLES = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/pmdio_cmd_build.sv
module pmdio_cmd_build
  import pmdio_pkg::*;
(
  input  seq_state_e  st,
  input  logic [15:0] wa,
  input  logic [31:0] acc,
  output logic        cmd_write,
  output logic [4:0]  cmd_phy,
  output logic [4:0]  cmd_reg,
  output logic [15:0] cmd_data
);
  always_comb begin
    cmd_write = 1'b0;
    cmd_phy   = phy_of(wa);
    cmd_reg   = lo_reg_of(wa);
    cmd_data  = 16'h0000;
    unique case (st)
      S_PAGE: begin
        cmd_write = 1'b1;
        cmd_phy   = PAGE_PHY;
        cmd_reg   = PAGE_REG;
        cmd_data  = {7'd0, page_of(wa)};
      end
      S_RHI:  cmd_reg = lo_reg_of(wa) | 5'd1;
      S_WLO: begin
        cmd_write = 1'b1;
        cmd_data  = acc[15:0];
      end
      S_WHI: begin
        cmd_write = 1'b1;
        cmd_reg   = lo_reg_of(wa) | 5'd1;
        cmd_data  = acc[31:16];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmdio_seq.sv
module pmdio_seq
  import pmdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [31:0] req_mask,
  input  logic        cmd_ready,
  input  logic        rsp_valid,
  input  logic [15:0] rsp_data,
  input  logic        settle_expired,
  output seq_state_e  st,
  output logic [15:0] wa,
  output logic [31:0] acc,
  output logic        cmd_valid
);
  logic [1:0]  op_q;
  logic [31:0] wdata_q, mask_q;
  logic        issued;
  logic        accept, cmd_fire, rsp_take;
  seq_state_e  after_rsp;

  assign cmd_valid = is_cmd_state(st) && !issued;
  assign accept    = (st == S_IDLE) && req_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign rsp_take  = issued && rsp_valid;

  always_comb begin
    unique case (st)
      S_PAGE:  after_rsp = S_SETTLE;
      S_RLO:   after_rsp = S_RHI;
      S_RHI:   after_rsp = (op_q == OP_RMW) ? S_WLO : S_DONE;
      S_WLO:   after_rsp = S_WHI;
      default: after_rsp = S_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      issued  <= 1'b0;
      op_q    <= OP_READ;
      wa      <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      acc     <= '0;
    end else begin
      if (cmd_fire) issued <= 1'b1;
      unique case (st)
        S_IDLE: if (accept) begin
          op_q    <= req_op;
          wa      <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          acc     <= req_wdata;
          st      <= S_PAGE;
        end
        S_SETTLE: if (settle_expired)
          st <= (op_q == OP_WRITE) ? S_WLO : S_RLO;
        S_DONE: st <= S_IDLE;
        default: if (rsp_take) begin
          issued <= 1'b0;
          st     <= after_rsp;
          if (st == S_RLO) acc[15:0] <= rsp_data;
          if (st == S_RHI) begin
            if (op_q == OP_RMW) acc <= merge({rsp_data, acc[15:0]}, mask_q, wdata_q);
            else                acc[31:16] <= rsp_data;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pmdio_bridge.sv
module pmdio_bridge
  import pmdio_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SETTLE_NS = 5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [31:0] req_mask,
  output logic        done,
  output logic [31:0] rdata,
  output logic        mdio_cmd_valid,
  input  logic        mdio_cmd_ready,
  output logic        mdio_cmd_write,
  output logic [4:0]  mdio_cmd_phy,
  output logic [4:0]  mdio_cmd_reg,
  output logic [15:0] mdio_cmd_data,
  input  logic        mdio_rsp_valid,
  input  logic [15:0] mdio_rsp_data
);
  localparam longint SETTLE_PROD = longint'(CLK_HZ) * longint'(SETTLE_NS);
  localparam int SETTLE_CYC = int'((SETTLE_PROD + 64'd999_999_999) / 64'd1_000_000_000);

  seq_state_e  st;
  logic [15:0] wa;
  logic [31:0] acc;
  logic        settle_expired;

  pmdio_seq u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask),
    .cmd_ready(mdio_cmd_ready), .rsp_valid(mdio_rsp_valid), .rsp_data(mdio_rsp_data),
    .settle_expired(settle_expired),
    .st(st), .wa(wa), .acc(acc), .cmd_valid(mdio_cmd_valid)
  );

  pmdio_settle_timer #(.CYCLES(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(st == S_SETTLE), .expired(settle_expired)
  );

  pmdio_cmd_build u_build (
    .st(st), .wa(wa), .acc(acc),
    .cmd_write(mdio_cmd_write), .cmd_phy(mdio_cmd_phy),
    .cmd_reg(mdio_cmd_reg), .cmd_data(mdio_cmd_data)
  );

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign rdata     = acc;
endmodule

// File: rtl/pmdio_bridge_chk.sv
module pmdio_bridge_chk #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SETTLE_NS = 5000
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        mdio_cmd_valid,
  input logic        mdio_cmd_ready,
  input logic        mdio_cmd_write,
  input logic [4:0]  mdio_cmd_phy,
  input logic [4:0]  mdio_cmd_reg,
  input logic [15:0] mdio_cmd_data,
  input logic        mdio_rsp_valid
);
  localparam longint PROD = longint'(CLK_HZ) * longint'(SETTLE_NS);
  localparam int SETTLE_CYC = int'((PROD + 64'd999_999_999) / 64'd1_000_000_000);

  logic        outstanding, last_page, armed;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      last_page   <= 1'b0;
      armed       <= 1'b0;
      gap         <= '0;
    end else begin
      if (mdio_cmd_valid && mdio_cmd_ready) begin
        outstanding <= 1'b1;
        last_page   <= (mdio_cmd_phy == 5'h18);
        if (mdio_cmd_phy != 5'h18) armed <= 1'b0;
      end else if (outstanding && mdio_rsp_valid) begin
        outstanding <= 1'b0;
        if (last_page) begin
          armed <= 1'b1;
          gap   <= '0;
        end
      end else if (armed && gap != 32'hFFFF_FFFF) begin
        gap <= gap + 1;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_ready && !done && !mdio_cmd_valid));

  assert_page_form_R2: assert property (@(posedge clk) disable iff (rst)
    (mdio_cmd_valid && mdio_cmd_phy == 5'h18) |->
      (mdio_cmd_write && mdio_cmd_reg == 5'd0 && mdio_cmd_data[15:9] == 7'd0));

  assert_settle_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (mdio_cmd_valid && armed && mdio_cmd_phy != 5'h18) |-> (gap >= 32'(SETTLE_CYC)));

  assert_single_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !mdio_cmd_valid);

  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mdio_cmd_valid && !mdio_cmd_ready) |=>
      (mdio_cmd_valid && $stable(mdio_cmd_phy) && $stable(mdio_cmd_reg) &&
       $stable(mdio_cmd_data) && $stable(mdio_cmd_write)));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mdio_cmd_valid);
endmodule

bind pmdio_bridge pmdio_bridge_chk #(.CLK_HZ(CLK_HZ), .SETTLE_NS(SETTLE_NS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .done(done),
  .mdio_cmd_valid(mdio_cmd_valid), .mdio_cmd_ready(mdio_cmd_ready),
  .mdio_cmd_write(mdio_cmd_write), .mdio_cmd_phy(mdio_cmd_phy),
  .mdio_cmd_reg(mdio_cmd_reg), .mdio_cmd_data(mdio_cmd_data),
  .mdio_rsp_valid(mdio_rsp_valid)
);

// File: tb/sim_pmdio_bridge.sv
module sim_pmdio_bridge;
  localparam int SETTLE = 625;   // 5000 ns at 8 ns per cycle

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = 16'd0;
  logic [31:0] req_wdata = 32'd0, req_mask = 32'd0;
  logic        done;
  logic [31:0] rdata;
  logic        mdio_cmd_valid, mdio_cmd_write;
  logic        mdio_cmd_ready = 1'b0;
  logic [4:0]  mdio_cmd_phy, mdio_cmd_reg;
  logic [15:0] mdio_cmd_data;
  logic        mdio_rsp_valid = 1'b0;
  logic [15:0] mdio_rsp_data = 16'd0;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] mem [0:1023];
  int          n_cmd = 0;
  logic [4:0]  lg_phy [0:15];
  logic [4:0]  lg_reg [0:15];
  logic        lg_wr  [0:15];
  logic [15:0] lg_dat [0:15];
  int          lg_seen [0:15];
  int          lg_rsp  [0:15];

  pmdio_bridge u0 (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // frame engine model
  initial begin
    int stall = 0, lat = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503) ^ 16'h5a5a;
    forever begin
      @(negedge clk);
      if (mdio_cmd_valid && !rst) begin
        logic [4:0] p, r; logic w; logic [15:0] d; int seen;
        p = mdio_cmd_phy; r = mdio_cmd_reg; w = mdio_cmd_write; d = mdio_cmd_data; seen = cyc;
        repeat (stall) @(negedge clk);
        stall = (stall + 1) % 3;
        chk(mdio_cmd_phy == p && mdio_cmd_reg == r && mdio_cmd_write == w && mdio_cmd_data == d,
            "R8 hold", {11'd0, mdio_cmd_phy, mdio_cmd_data}, {11'd0, p, d});
        mdio_cmd_ready = 1'b1;
        @(negedge clk);
        mdio_cmd_ready = 1'b0;
        chk(!mdio_cmd_valid, "R8 single", {31'd0, mdio_cmd_valid}, 32'd0);
        repeat (lat) @(negedge clk);
        lat = (lat + 2) % 3;
        if (w) mem[{p, r}] = d;
        else   mdio_rsp_data = mem[{p, r}];
        if (n_cmd < 16) begin
          lg_phy[n_cmd] = p; lg_reg[n_cmd] = r; lg_wr[n_cmd] = w;
          lg_dat[n_cmd] = d; lg_seen[n_cmd] = seen; lg_rsp[n_cmd] = cyc;
        end
        n_cmd++;
        mdio_rsp_valid = 1'b1;
        @(negedge clk);
        mdio_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_req(input logic [1:0] op, input logic [31:0] byte_addr,
                        input logic [31:0] wd, input logic [31:0] mk);
    logic [8:0] page; logic [4:0] phy, rl; logic [31:0] old_v, exp_v;
    logic [4:0] e_reg [0:4]; logic e_wr [0:4]; logic [15:0] e_dat [0:4];
    int ne, guard;
    string tag;
    page  = byte_addr[17:9];
    phy   = 5'h10 | {2'b0, byte_addr[8:6]};
    rl    = (byte_addr[5:1]) & 5'h1E;
    old_v = {mem[{phy, rl + 5'd1}], mem[{phy, rl}]};
    if (op == 2'd1)      begin exp_v = wd; tag = "R6"; end
    else if (op == 2'd2) begin exp_v = (old_v & ~mk) | wd; tag = "R7"; end
    else                 begin exp_v = old_v; tag = "R5"; end
    if (op == 2'd1) begin
      ne = 2;
      e_reg[0] = rl; e_wr[0] = 1; e_dat[0] = wd[15:0];
      e_reg[1] = rl + 5'd1; e_wr[1] = 1; e_dat[1] = wd[31:16];
    end else begin
      e_reg[0] = rl; e_wr[0] = 0; e_dat[0] = 0;
      e_reg[1] = rl + 5'd1; e_wr[1] = 0; e_dat[1] = 0;
      ne = 2;
      if (op == 2'd2) begin
        ne = 4;
        e_reg[2] = rl; e_wr[2] = 1; e_dat[2] = exp_v[15:0];
        e_reg[3] = rl + 5'd1; e_wr[3] = 1; e_dat[3] = exp_v[31:16];
      end
    end
    n_cmd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = byte_addr[17:2]; req_wdata = wd; req_mask = mk;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy", {31'd0, req_ready}, 32'd0);
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(rdata == exp_v, tag, rdata, exp_v);
    @(negedge clk);
    chk(!done && req_ready, "R9 pulse", {30'd0, done, req_ready}, 32'd1);
    chk(n_cmd == ne + 1, "R8 count", n_cmd, ne + 1);
    chk(lg_phy[0] == 5'h18 && lg_reg[0] == 0 && lg_wr[0] && lg_dat[0] == {7'd0, page},
        "R2 page", {lg_wr[0], lg_phy[0], lg_reg[0], lg_dat[0]}, {1'b1, 5'h18, 5'd0, 7'd0, page});
    chk(lg_seen[1] - lg_rsp[0] == SETTLE + 1 && (lg_seen[1] - lg_rsp[0]) * 8 >= 5000,
        "R3 settle", lg_seen[1] - lg_rsp[0], SETTLE + 1);
    for (int i = 0; i < ne; i++)
      chk(lg_phy[i+1] == phy && lg_reg[i+1] == e_reg[i] && lg_wr[i+1] == e_wr[i] &&
          (!e_wr[i] || lg_dat[i+1] == e_dat[i]),
          (i == 0) ? "R4 lo" : {"R4 ", tag},
          {lg_wr[i+1], lg_phy[i+1], lg_reg[i+1], lg_dat[i+1]},
          {e_wr[i], phy, e_reg[i], e_dat[i]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && !mdio_cmd_valid, "R1 reset state",
        {29'd0, req_ready, done, mdio_cmd_valid}, 32'h4);

    for (int k = 0; k < 48; k++) begin
      logic [31:0] a;
      a = {14'h2a5 ^ 14'(k), 9'(k * 37), 3'(k), 4'(k * 5), 2'(k)};
      do_req(2'(k % 4), a, 32'h9e3779b9 * (k + 1), 32'hff00_f0f0 ^ (32'h1111 * k));
    end
    // boundary: highest page, phy select and register pair
    do_req(2'd1, 32'h0003_FFFC, 32'hDEAD_BEEF, 32'd0);
    do_req(2'd2, 32'h0003_FFFC, 32'h0000_0001, 32'hFFFF_FFFF);
    do_req(2'd0, 32'h0003_FFFC, 32'd0, 32'd0);
    do_req(2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);

    // R1: reset during settle wait drops the request
    begin
      int quiet;
      n_cmd = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd2; req_addr = 16'h1234; req_wdata = 32'h1; req_mask = 32'h3;
      @(negedge clk);
      req_valid = 1'b0;
      while (n_cmd < 1) @(negedge clk);
      repeat (50) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk(req_ready && !done, "R1 abort idle", {30'd0, req_ready, done}, 32'h2);
      quiet = 0;
      for (int i = 0; i < 800; i++) begin
        @(negedge clk);
        if (mdio_cmd_valid || done || !req_ready) quiet++;
      end
      chk(quiet == 0 && n_cmd == 1, "R1 no commands after abort", quiet, 0);
    end
    do_req(2'd0, 32'h0000_48D0, 32'd0, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule